// File: doc/BRIEF.md
# Oblivious Path-Tree Access Controller

This block serves reads and writes to a small set of logical data blocks while hiding from the storage which block each request touches. The storage is a binary tree of buckets held in on-chip registers. Each bucket has Z slots, and each leaf names one path from the root down to that leaf. Every logical block is tied to a random leaf through a position map. The block is always either somewhere on the path to its leaf or in a small stash inside the controller.

Each accepted request goes through the same fixed steps. The controller reads every slot of every bucket on the path to the block's current leaf, from the root down, and moves the real blocks it finds into the stash. It then serves the read or write from the stash and ties the block to a fresh pseudo-random leaf. Last, it writes the same path back from the leaf bucket up to the root. Each slot takes the first stash block that may legally live there and is otherwise marked empty. The storage therefore sees one full path read and one full path write per request, whatever the operation and address.

The tree traffic is brought out on observation ports (read strobe, write strobe and bucket index) so that the access shape can be watched from outside. Leaves come from a free-running linear feedback shift register. A sticky flag records any attempt to insert into a full stash.

Top module: `oram_ctl`

## Requirements
- R1: After reset release `resp_valid` and `stash_ovf` are 0, and `req_ready` stays low for exactly 2^AW cycles while the position map is seeded. It is high from the 2^AW-th cycle on.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays low from acceptance until the response cycle has ended, and a request raised while busy has no effect on the stored data.
- R3: After acceptance the path is read for Z cycles per bucket with `tree_rd`=1, from depth 0 to depth LEAF_BITS. Buckets use heap numbering: the root is 0 and the children of b are 2b+1 and 2b+2. Each step goes to a child of the previous bucket.
- R4: One cycle with neither strobe follows the read. Then the same buckets are written with `tree_wr`=1, Z cycles each, from the leaf bucket up to the root, and `tree_rd` and `tree_wr` are never both 1.
- R5: `resp_valid` is a one-cycle pulse that rises exactly 2·(LEAF_BITS+1)·Z+1 clock edges after the accepting edge, for reads and writes alike.
- R6: A read (`req_write`=0) returns in `resp_rdata` the data most recently written to that address, across any number of evictions.
- R7: A read of an address never written since reset returns 0.
- R8: A write (`req_write`=1) returns in `resp_rdata` the value that the address held before the write (0 if it was never written).
- R9: `stash_ovf` is sticky once set. With no more logical blocks than stash entries (the default), it never sets.
- R10: Every access gives the block a new leaf, so repeated accesses to one address do not all walk the same path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Logical block address |
| req_wdata | input | DW | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DW | Read data, or old data for a write |
| tree_rd | output | 1 | Tree slot read in this cycle |
| tree_wr | output | 1 | Tree slot written in this cycle |
| tree_bkt | output | clog2(2^(LEAF_BITS+1)-1) | Bucket index of the current tree access |
| stash_ovf | output | 1 | Sticky stash overflow flag |

## Verification
A stimulus table mixes reads and writes to a few addresses. It separates fresh-address zeros, overwrite returns of old data, and reads after other blocks have been evicted into the same tree. A second phase writes every address and then reads them all back twice in reverse order. With the tree full, this stresses greedy eviction and shows whether any block is lost or misplaced. On every access the bench follows the bucket sequence to confirm a legal root-to-leaf path, its exact mirror on write-back and a constant response latency. A request raised during a busy period, and a run of repeated reads of one address, show that busy requests are dropped and that the path changes between accesses.

// File: rtl/oram_ctl.sv
module oram_ctl #(
  parameter int LEAF_BITS = 3,
  parameter int Z         = 2,
  parameter int AW        = 3,
  parameter int DW        = 16,
  parameter int STASH     = 8,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 resp_valid,
  output logic [DW-1:0]        resp_rdata,
  output logic                 tree_rd,
  output logic                 tree_wr,
  output logic [$clog2((2<<LEAF_BITS)-1)-1:0] tree_bkt,
  output logic                 stash_ovf
);
  localparam int NLEAF = 1 << LEAF_BITS;
  localparam int NBKT  = 2 * NLEAF - 1;
  localparam int NTS   = NBKT * Z;
  localparam int NBLK  = 1 << AW;
  localparam int BKT_W = $clog2(NBKT);
  localparam int TS_W  = $clog2(NTS);
  localparam int SI_W  = (STASH > 1) ? $clog2(STASH) : 1;
  localparam int DEP_W = $clog2(LEAF_BITS + 1);
  localparam int SL_W  = (Z > 1) ? $clog2(Z) : 1;

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_READ, S_SERVE, S_WRITE, S_RESP} st_t;
  st_t st;

  logic                 tv [NTS];
  logic [AW-1:0]        ta [NTS];
  logic [LEAF_BITS-1:0] tl [NTS];
  logic [DW-1:0]        td [NTS];

  logic                 sv [STASH];
  logic [AW-1:0]        sa [STASH];
  logic [LEAF_BITS-1:0] sl [STASH];
  logic [DW-1:0]        sd [STASH];

  logic [LEAF_BITS-1:0] posmap [NBLK];

  logic [DEP_W-1:0]     dep;
  logic [SL_W-1:0]      slt;
  logic [AW-1:0]        icnt;
  logic                 r_write;
  logic [AW-1:0]        r_addr;
  logic [DW-1:0]        r_wdata;
  logic [LEAF_BITS-1:0] cur_leaf;
  logic [LFSR_W-1:0]    lfsr;
  logic                 ovf;
  logic [DW-1:0]        rdata;

  logic [LEAF_BITS-1:0] new_leaf;
  logic [DEP_W:0]       sh;
  int                   bi;
  logic [BKT_W-1:0]     bkt;
  logic [TS_W-1:0]      ts;
  logic                 fr_ok, hit, ev_ok;
  logic [SI_W-1:0]      fr_idx, hidx, ev_idx;
  logic                 last_slot;

  assign new_leaf  = lfsr[LEAF_BITS-1:0];
  assign sh        = (DEP_W+1)'(LEAF_BITS) - {1'b0, dep};
  assign last_slot = (slt == SL_W'(Z - 1));

  always_comb begin
    bi  = (1 << dep) - 1 + int'(cur_leaf >> sh);
    bkt = BKT_W'(bi);
    ts  = TS_W'(bi * Z + int'(slt));
  end

  always_comb begin
    fr_ok = 1'b0; fr_idx = '0;
    hit   = 1'b0; hidx   = '0;
    ev_ok = 1'b0; ev_idx = '0;
    for (int i = STASH - 1; i >= 0; i--) begin
      if (!sv[i]) begin fr_ok = 1'b1; fr_idx = SI_W'(i); end
      if (sv[i] && sa[i] == r_addr) begin hit = 1'b1; hidx = SI_W'(i); end
      if (sv[i] && (((sl[i] ^ cur_leaf) >> sh) == '0)) begin
        ev_ok = 1'b1; ev_idx = SI_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_W'(1);
    else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ LFSR_TAPS;
    else lfsr <= lfsr >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_INIT;
      icnt     <= '0;
      dep      <= '0;
      slt      <= '0;
      ovf      <= 1'b0;
      rdata    <= '0;
      r_write  <= 1'b0;
      r_addr   <= '0;
      r_wdata  <= '0;
      cur_leaf <= '0;
      for (int i = 0; i < NTS; i++) tv[i] <= 1'b0;
      for (int i = 0; i < STASH; i++) sv[i] <= 1'b0;
    end else begin
      case (st)
        S_INIT: begin
          posmap[icnt] <= new_leaf;
          icnt <= icnt + 1'b1;
          if (icnt == AW'(NBLK - 1)) st <= S_IDLE;
        end
        S_IDLE: begin
          if (req_valid) begin
            r_write  <= req_write;
            r_addr   <= req_addr;
            r_wdata  <= req_wdata;
            cur_leaf <= posmap[req_addr];
            dep      <= '0;
            slt      <= '0;
            st       <= S_READ;
          end
        end
        S_READ: begin
          if (tv[ts]) begin
            if (fr_ok) begin
              sv[fr_idx] <= 1'b1;
              sa[fr_idx] <= ta[ts];
              sl[fr_idx] <= tl[ts];
              sd[fr_idx] <= td[ts];
            end else begin
              ovf <= 1'b1;
            end
          end
          tv[ts] <= 1'b0;
          if (last_slot) begin
            slt <= '0;
            if (dep == DEP_W'(LEAF_BITS)) st <= S_SERVE;
            else dep <= dep + 1'b1;
          end else begin
            slt <= slt + 1'b1;
          end
        end
        S_SERVE: begin
          posmap[r_addr] <= new_leaf;
          if (hit) begin
            rdata    <= sd[hidx];
            sl[hidx] <= new_leaf;
            if (r_write) sd[hidx] <= r_wdata;
          end else begin
            rdata <= '0;
            if (fr_ok) begin
              sv[fr_idx] <= 1'b1;
              sa[fr_idx] <= r_addr;
              sl[fr_idx] <= new_leaf;
              sd[fr_idx] <= r_write ? r_wdata : '0;
            end else begin
              ovf <= 1'b1;
            end
          end
          dep <= DEP_W'(LEAF_BITS);
          slt <= '0;
          st  <= S_WRITE;
        end
        S_WRITE: begin
          if (ev_ok) begin
            tv[ts]     <= 1'b1;
            ta[ts]     <= sa[ev_idx];
            tl[ts]     <= sl[ev_idx];
            td[ts]     <= sd[ev_idx];
            sv[ev_idx] <= 1'b0;
          end else begin
            tv[ts] <= 1'b0;
          end
          if (last_slot) begin
            slt <= '0;
            if (dep == '0) st <= S_RESP;
            else dep <= dep - 1'b1;
          end else begin
            slt <= slt + 1'b1;
          end
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_RESP);
  assign resp_rdata = rdata;
  assign tree_rd    = (st == S_READ);
  assign tree_wr    = (st == S_WRITE);
  assign tree_bkt   = bkt;
  assign stash_ovf  = ovf;
endmodule

// File: rtl/oram_ctl_chk.sv
module oram_ctl_chk #(
  parameter int LEAF_BITS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic tree_rd,
  input logic tree_wr,
  input logic [$clog2((2<<LEAF_BITS)-1)-1:0] tree_bkt,
  input logic stash_ovf
);
  AST_ACCEPT_READS_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (tree_rd && tree_bkt == '0)); // R3
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tree_rd || tree_wr || resp_valid) |-> !req_ready); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tree_rd && tree_wr)); // R4
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready)); // R5
  AST_RESP_AFTER_ROOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(tree_wr) && $past(tree_bkt) == '0)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stash_ovf |=> stash_ovf); // R9
endmodule

bind oram_ctl oram_ctl_chk #(.LEAF_BITS(LEAF_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .tree_rd(tree_rd), .tree_wr(tree_wr),
  .tree_bkt(tree_bkt), .stash_ovf(stash_ovf)
);

// File: tb/oram_ctl_test.sv
module oram_ctl_test;
  localparam int LB = 3;
  localparam int ZS = 2;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NB = 1 << AW;
  localparam int PS = (LB + 1) * ZS;
  localparam int BW = $clog2((2 << LB) - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, tree_rd, tree_wr, stash_ovf;
  logic [DW-1:0] resp_rdata;
  logic [BW-1:0] tree_bkt;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [NB];

  always #5 clk = ~clk;

  oram_ctl #(.LEAF_BITS(LB), .Z(ZS), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .tree_rd(tree_rd),
    .tree_wr(tree_wr), .tree_bkt(tree_bkt), .stash_ovf(stash_ovf)
  );

  // {write, addr, wdata, expected rdata}
  localparam int NV = 14;
  localparam logic [1+AW+DW+DW-1:0] VEC [NV] = '{
    {1'b0, 3'd3, 16'h0000, 16'h0000},
    {1'b1, 3'd3, 16'h1111, 16'h0000},
    {1'b0, 3'd3, 16'h0000, 16'h1111},
    {1'b1, 3'd0, 16'h00AA, 16'h0000},
    {1'b1, 3'd7, 16'h7777, 16'h0000},
    {1'b1, 3'd3, 16'h3333, 16'h1111},
    {1'b0, 3'd0, 16'h0000, 16'h00AA},
    {1'b0, 3'd7, 16'h0000, 16'h7777},
    {1'b0, 3'd3, 16'h0000, 16'h3333},
    {1'b1, 3'd5, 16'h5A5A, 16'h0000},
    {1'b0, 3'd1, 16'h0000, 16'h0000},
    {1'b0, 3'd5, 16'h0000, 16'h5A5A},
    {1'b1, 3'd0, 16'h0BEE, 16'h00AA},
    {1'b0, 3'd0, 16'h0000, 16'h0BEE}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit inject, output logic [DW-1:0] rd, output int leaf_bkt);
    int rb [LB+1];
    bit rd_ok, wr_ok, gap_ok, rdy_ok;
    int n, dd, lat;
    rd_ok = 1; wr_ok = 1; gap_ok = 1; rdy_ok = 1; lat = -1;
    while (!req_ready) @(negedge clk);
    req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (n = 1; n <= 2 * PS + 4; n++) begin
      if (inject && n == 5) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd6; req_wdata = 16'hDEAD;
      end
      if (inject && n == 6) req_valid = 1'b0;
      if (resp_valid) begin lat = n; break; end
      if (req_ready) rdy_ok = 0;
      if (n <= PS) begin
        dd = (n - 1) / ZS;
        if (!tree_rd || tree_wr) rd_ok = 0;
        if ((n - 1) % ZS == 0) begin
          rb[dd] = int'(tree_bkt);
          if (dd == 0 && rb[0] != 0) rd_ok = 0;
          if (dd > 0 && rb[dd] != 2 * rb[dd-1] + 1 && rb[dd] != 2 * rb[dd-1] + 2) rd_ok = 0;
        end else if (int'(tree_bkt) != rb[dd]) rd_ok = 0;
      end else if (n == PS + 1) begin
        if (tree_rd || tree_wr) gap_ok = 0;
      end else begin
        dd = LB - (n - PS - 2) / ZS;
        if (dd < 0 || !tree_wr || tree_rd || int'(tree_bkt) != rb[dd]) wr_ok = 0;
      end
      @(negedge clk);
    end
    rd = resp_rdata;
    leaf_bkt = rb[LB];
    chk(rd_ok, "R3 path read shape", rd_ok, 1);
    chk(wr_ok && gap_ok, "R4 write-back mirrors read", wr_ok && gap_ok, 1);
    chk(rdy_ok, "R2 ready low while busy", rdy_ok, 1);
    chk(lat == 2 * PS + 2, "R5 response latency", lat, 2 * PS + 2);
    @(negedge clk);
    chk(!resp_valid && req_ready, "R5 single-cycle response", resp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int lb, k, first_leaf, distinct;
    for (int i = 0; i < NB; i++) model[i] = '0;

    repeat (3) @(negedge clk);
    chk(!resp_valid, "R1 resp_valid in reset", resp_valid, 0);
    chk(!stash_ovf, "R1 overflow in reset", stash_ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1 ready low during seeding", req_ready, 0);
    k = 1;
    while (!req_ready && k < 50) begin @(negedge clk); k++; end
    chk(k == NB, "R1 seeding length", k, NB);
    chk(!resp_valid && !stash_ovf, "R1 idle after seeding", {resp_valid, stash_ovf}, 0);

    for (int v = 0; v < NV; v++) begin
      logic w; logic [AW-1:0] a; logic [DW-1:0] d, e;
      {w, a, d, e} = VEC[v];
      access(w, a, d, 1'b0, rd, lb);
      if (w) begin
        model[a] = d;
        chk(rd == e, "R8 write returns old data", rd, e);
      end else if (e == '0) chk(rd == e, "R7 unwritten reads zero", rd, e);
      else chk(rd == e, "R6 read returns last write", rd, e);
    end

    access(1'b0, 3'd2, '0, 1'b1, rd, lb);
    chk(rd == '0, "R7 unwritten address 2", rd, 0);
    access(1'b0, 3'd6, '0, 1'b0, rd, lb);
    chk(rd == '0, "R2 busy request ignored", rd, 0);

    for (int i = 0; i < NB; i++) begin
      logic [DW-1:0] nv;
      nv = 16'h1000 + DW'(i) * 16'h0111;
      access(1'b1, AW'(i), nv, 1'b0, rd, lb);
      chk(rd == model[i], "R8 full-tree write old data", rd, model[i]);
      model[i] = nv;
    end
    for (int p = 0; p < 2; p++) begin
      for (int i = NB - 1; i >= 0; i--) begin
        access(1'b0, AW'(i), '0, 1'b0, rd, lb);
        chk(rd == model[i], "R6 read after eviction", rd, model[i]);
      end
    end

    distinct = 0;
    first_leaf = -1;
    for (int r = 0; r < 16; r++) begin
      access(1'b0, 3'd4, '0, 1'b0, rd, lb);
      chk(rd == model[4], "R6 repeated read", rd, model[4]);
      if (first_leaf < 0) first_leaf = lb;
      else if (lb != first_leaf) distinct = 1;
    end
    chk(distinct == 1, "R10 path changes between accesses", distinct, 1);

    chk(!stash_ovf, "R9 no overflow with capacity for all blocks", stash_ovf, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule